// File: doc/BRIEF.md
# I2C Packet Header Decoder

This block sits between a transmit word FIFO and an I2C master bit engine. Each transfer is described entirely in-band. Three header words come first. The first word is accepted and not inspected. The second word carries the payload length minus one. The third word carries the target address, the direction and the control bits. From these the block builds one command for the bit engine. The command holds the address, the addressing width, the direction, the byte count, the speed mode, the NACK policy and what the engine does at the end of the packet.

For a write, the payload words that follow the header are split into bytes and handed to the engine, lowest byte first. For a read, bytes from the engine are packed into words for the receive FIFO. The engine reports completion and bus errors on plain pulse inputs. The block turns these into a per-packet completion pulse and into error pulses. After a fatal error it discards the rest of the packet's payload, so that the next header is found in the right place.

All data paths are valid/ready streams. A beat transfers on a rising clock edge when both valid and ready are high. Once a sender raises valid, it holds valid and its data unchanged until the beat transfers. The block never makes its own valid outputs depend on the ready inputs.

Top module: `pkt_hdr_decoder`

## Requirements
- R1: The block accepts three header words in turn. The first is not inspected. The low 12 bits of the second word appear on cmd_len as the byte count minus one. Exactly one command is offered after the third word.
- R2: When bit 18 of the third word is set, cmd_ten_bit is 1 and cmd_addr is bits 9:0 of that word. Otherwise cmd_ten_bit is 0 and cmd_addr is {3'b000, bits 7:1}.
- R3: cmd_end is 2'd1 (repeated start) when bit 16 of the third word is set, and bit 16 wins over bit 15. It is 2'd2 (continue, no stop or start) when only bit 15 is set. It is 2'd0 (stop) when neither bit is set.
- R4: cmd_read equals bit 19, cmd_hs equals bit 22 and cmd_nack_ok equals bit 21 of the third word.
- R5: For a write of N bytes, exactly ceil(N/4) payload words are taken from tx. Exactly N bytes leave on wb, and each word gives its bits 7:0 first, then 15:8, then 23:16, then 31:24. Unused bytes of a final partial word are dropped.
- R6: For a read of N bytes, the bytes from rb are packed little-endian into ceil(N/4) rx words, with the first byte in bits 7:0. In a final partial word the unused upper bytes are zero.
- R7: On the tx, cmd, wb, rb and rx interfaces a beat transfers only when valid and ready are both high at a clock edge. An offered command, byte or rx word stays valid and unchanged until it is taken.
- R8: pkt_done pulses high for one cycle after eng_done is seen for a packet whose third word has bit 17 set. It stays low for a packet with bit 17 clear. Either way the next header is then accepted.
- R9: err_nack or err_arb pulses high for one cycle, one cycle after eng_nack or eng_arb is high during a packet.
- R10: On arbitration loss, or on a NACK when bit 21 is clear, byte traffic stops at once. The block then consumes and discards the packet's remaining payload words, waits for eng_done, and decodes the following words as a new header.
- R11: On a NACK when bit 21 is set, err_nack still pulses, but every byte of the packet is still forwarded.
- R12: After reset the block is ready for a header word (tx_ready high). cmd_valid, wb_valid, rx_valid, pkt_done, err_nack and err_arb are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Transmit FIFO word available |
| tx_ready | output | 1 | Block takes the tx word |
| tx_data | input | 32 | Header or payload word |
| cmd_valid | output | 1 | Command offered to the bit engine |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_addr | output | 10 | Target address |
| cmd_ten_bit | output | 1 | 10-bit addressing |
| cmd_read | output | 1 | Read transfer |
| cmd_hs | output | 1 | High-speed mode |
| cmd_nack_ok | output | 1 | Continue after NACK |
| cmd_end | output | 2 | End action: 0 stop, 1 repeated start, 2 continue |
| cmd_len | output | LEN_W | Byte count minus one |
| wb_valid | output | 1 | Write byte offered |
| wb_ready | input | 1 | Engine takes the write byte |
| wb_data | output | 8 | Write byte |
| rb_valid | input | 1 | Read byte offered by the engine |
| rb_ready | output | 1 | Block takes the read byte |
| rb_data | input | 8 | Read byte |
| rx_valid | output | 1 | Receive word offered |
| rx_ready | input | 1 | Receive FIFO takes the word |
| rx_data | output | 32 | Packed receive word |
| eng_done | input | 1 | Engine finished the packet, including the bus stop |
| eng_nack | input | 1 | Engine saw a NACK |
| eng_arb | input | 1 | Engine lost arbitration |
| pkt_done | output | 1 | Packet completion pulse |
| err_nack | output | 1 | NACK error pulse |
| err_arb | output | 1 | Arbitration-loss pulse |

## Verification
The bench feeds lengths that end in partial words (5 and 7 bytes) with gaps in the ready and valid signals. A wrong byte order, an extra byte or a missing zero fill shows up directly in the collected bytes and words. For the error cases, a second packet follows the failing one straight away in the word stream. If the block drains one word too few or one too many, it takes a payload word as a header, and the second command's length and bytes come out wrong. Both end-action bits are set together to catch an inverted priority. The completion pulse is counted with bit 17 set and with it clear.

// File: rtl/pkt_hdr_pkg.sv
package pkt_hdr_pkg;
  localparam int WORD_W = 32;
  localparam int NB     = WORD_W / 8;
  localparam int IDX_W  = $clog2(NB);

  // positions inside the packed control slice {w[22:21], w[19:15]}
  localparam int C_CONT   = 0;
  localparam int C_RSTART = 1;
  localparam int C_IE     = 2;
  localparam int C_TEN    = 3;
  localparam int C_RD     = 4;
  localparam int C_NACKOK = 5;
  localparam int C_HS     = 6;

  typedef enum logic [1:0] {
    END_STOP   = 2'd0,
    END_RSTART = 2'd1,
    END_CONT   = 2'd2
  } end_act_e;

  typedef enum logic [2:0] {
    S_HDR0, S_HDR1, S_HDR2, S_ISSUE, S_XFER, S_DRAIN, S_WAIT
  } dec_st_e;

  typedef struct packed {
    logic [9:0] addr;
    logic       ten;
    logic       rd;
    logic       hs;
    logic       nack_ok;
    logic       ie;
    end_act_e   act;
  } xfer_cmd_t;
endpackage

// File: rtl/hdr_field_decode.sv
module hdr_field_decode
  import pkt_hdr_pkg::*;
(
  input  logic [6:0] ctl_i,
  input  logic [9:0] adr_i,
  output xfer_cmd_t  cmd_o
);
  always_comb begin
    cmd_o.ten     = ctl_i[C_TEN];
    cmd_o.rd      = ctl_i[C_RD];
    cmd_o.hs      = ctl_i[C_HS];
    cmd_o.nack_ok = ctl_i[C_NACKOK];
    cmd_o.ie      = ctl_i[C_IE];
    cmd_o.addr    = ctl_i[C_TEN] ? adr_i : {3'b000, adr_i[7:1]};
    if (ctl_i[C_RSTART])    cmd_o.act = END_RSTART;
    else if (ctl_i[C_CONT]) cmd_o.act = END_CONT;
    else                    cmd_o.act = END_STOP;
  end
endmodule

// File: rtl/wr_unpack.sv
module wr_unpack
  import pkt_hdr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              take_i,
  input  logic              last_i,
  input  logic              flush_i,
  output logic              full_o,
  output logic [7:0]        byte_o
);
  logic [WORD_W-1:0] hold_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_o <= 1'b0;
      idx_q  <= '0;
      hold_q <= '0;
    end else if (flush_i) begin
      full_o <= 1'b0;
      idx_q  <= '0;
    end else if (load_i) begin
      hold_q <= word_i;
      idx_q  <= '0;
      full_o <= 1'b1;
    end else if (take_i) begin
      if (idx_q == IDX_W'(NB - 1) || last_i) begin
        full_o <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign byte_o = hold_q[idx_q*8 +: 8];

  AST_LOAD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !full_o); // R5
endmodule

// File: rtl/rd_pack.sv
module rd_pack
  import pkt_hdr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [7:0]        byte_i,
  input  logic              last_i,
  input  logic              flush_i,
  input  logic              out_ready_i,
  output logic              can_take_o,
  output logic              out_valid_o,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] acc_q, merged;
  logic [IDX_W-1:0]  idx_q;

  always_comb begin
    merged = acc_q;
    merged[idx_q*8 +: 8] = byte_i;
  end

  assign can_take_o = !out_valid_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q       <= '0;
      idx_q       <= '0;
      out_valid_o <= 1'b0;
      word_o      <= '0;
    end else if (flush_i) begin
      acc_q       <= '0;
      idx_q       <= '0;
      out_valid_o <= 1'b0;
    end else begin
      if (out_valid_o && out_ready_i) out_valid_o <= 1'b0;
      if (take_i) begin
        if (idx_q == IDX_W'(NB - 1) || last_i) begin
          word_o      <= merged;
          out_valid_o <= 1'b1;
          acc_q       <= '0;
          idx_q       <= '0;
        end else begin
          acc_q <= merged;
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i |=> $stable(word_o)); // R7
endmodule

// File: rtl/pkt_hdr_decoder.sv
module pkt_hdr_decoder
  import pkt_hdr_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [WORD_W-1:0] tx_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [9:0]        cmd_addr,
  output logic              cmd_ten_bit,
  output logic              cmd_read,
  output logic              cmd_hs,
  output logic              cmd_nack_ok,
  output logic [1:0]        cmd_end,
  output logic [LEN_W-1:0]  cmd_len,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [7:0]        wb_data,
  input  logic              rb_valid,
  output logic              rb_ready,
  input  logic [7:0]        rb_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [WORD_W-1:0] rx_data,
  input  logic              eng_done,
  input  logic              eng_nack,
  input  logic              eng_arb,
  output logic              pkt_done,
  output logic              err_nack,
  output logic              err_arb
);
  localparam int CNT_W = LEN_W + 1;

  dec_st_e          st;
  xfer_cmd_t        cmd_q, cmd_d;
  logic [LEN_W-1:0] len_q;
  logic [CNT_W-1:0] brem;
  logic [LEN_W-1:0] wrem;
  logic             done_seen, busy, pop, err_stop;
  logic             up_full, pk_can, take_w, take_r, last_b, flush;

  hdr_field_decode u_dec (
    .ctl_i ({tx_data[22:21], tx_data[19:15]}),
    .adr_i (tx_data[9:0]),
    .cmd_o (cmd_d)
  );

  assign busy     = (st == S_XFER) || (st == S_DRAIN) || (st == S_WAIT);
  assign err_stop = eng_arb || (eng_nack && !cmd_q.nack_ok);
  assign last_b   = (brem == CNT_W'(1));
  assign flush    = (st == S_XFER) && err_stop;

  always_comb begin
    unique case (st)
      S_HDR0, S_HDR1, S_HDR2: tx_ready = 1'b1;
      S_XFER:  tx_ready = !cmd_q.rd && !up_full && (wrem != '0);
      S_DRAIN: tx_ready = (wrem != '0);
      default: tx_ready = 1'b0;
    endcase
  end
  assign pop = tx_valid && tx_ready;

  assign wb_valid = (st == S_XFER) && up_full;
  assign take_w   = wb_valid && wb_ready;
  assign rb_ready = (st == S_XFER) && cmd_q.rd && pk_can && (brem != '0);
  assign take_r   = rb_valid && rb_ready;

  wr_unpack u_unpack (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (pop && (st == S_XFER)),
    .word_i  (tx_data),
    .take_i  (take_w),
    .last_i  (last_b),
    .flush_i (flush),
    .full_o  (up_full),
    .byte_o  (wb_data)
  );

  rd_pack u_pack (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_i      (take_r),
    .byte_i      (rb_data),
    .last_i      (last_b),
    .flush_i     (flush),
    .out_ready_i (rx_ready),
    .can_take_o  (pk_can),
    .out_valid_o (rx_valid),
    .word_o      (rx_data)
  );

  assign cmd_valid   = (st == S_ISSUE);
  assign cmd_addr    = cmd_q.addr;
  assign cmd_ten_bit = cmd_q.ten;
  assign cmd_read    = cmd_q.rd;
  assign cmd_hs      = cmd_q.hs;
  assign cmd_nack_ok = cmd_q.nack_ok;
  assign cmd_end     = cmd_q.act;
  assign cmd_len     = len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_HDR0;
      cmd_q     <= '0;
      len_q     <= '0;
      brem      <= '0;
      wrem      <= '0;
      done_seen <= 1'b0;
      pkt_done  <= 1'b0;
      err_nack  <= 1'b0;
      err_arb   <= 1'b0;
    end else begin
      pkt_done <= 1'b0;
      err_nack <= busy && eng_nack;
      err_arb  <= busy && eng_arb;
      if (busy && eng_done) done_seen <= 1'b1;
      if (pop && (st == S_XFER || st == S_DRAIN)) wrem <= wrem - 1'b1;
      if (take_w || take_r) brem <= brem - 1'b1;
      unique case (st)
        S_HDR0: if (pop) st <= S_HDR1;
        S_HDR1: if (pop) begin
          len_q <= tx_data[LEN_W-1:0];
          st    <= S_HDR2;
        end
        S_HDR2: if (pop) begin
          cmd_q     <= cmd_d;
          done_seen <= 1'b0;
          st        <= S_ISSUE;
        end
        S_ISSUE: if (cmd_ready) begin
          brem <= {1'b0, len_q} + CNT_W'(1);
          wrem <= cmd_q.rd ? '0 : (len_q >> IDX_W) + LEN_W'(1);
          st   <= S_XFER;
        end
        S_XFER: begin
          if (err_stop) st <= S_DRAIN;
          else if (brem == '0 && !rx_valid && !up_full) st <= S_WAIT;
        end
        S_DRAIN: if (wrem == '0) st <= S_WAIT;
        S_WAIT: if (done_seen || eng_done) begin
          pkt_done <= cmd_q.ie;
          st       <= S_HDR0;
        end
        default: st <= S_HDR0;
      endcase
    end
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_len) && $stable(cmd_end)); // R7
  AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready && !eng_nack && !eng_arb |=> wb_valid && $stable(wb_data)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> !pkt_done); // R8
  AST_NO_BYTES_IN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st == S_DRAIN) && st == S_DRAIN |-> !rx_valid); // R10
endmodule

// File: tb/pkt_hdr_decoder_tb_top.sv
module pkt_hdr_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        tx_valid, tx_ready;
  logic [31:0] tx_data;
  logic        cmd_valid, cmd_ready, cmd_ten_bit, cmd_read, cmd_hs, cmd_nack_ok;
  logic [9:0]  cmd_addr;
  logic [1:0]  cmd_end;
  logic [11:0] cmd_len;
  logic        wb_valid, wb_ready, rb_valid, rb_ready, rx_valid, rx_ready;
  logic [7:0]  wb_data, rb_data;
  logic [31:0] rx_data;
  logic        eng_done, eng_nack, eng_arb, pkt_done, err_nack, err_arb;

  pkt_hdr_decoder dut_i (.*);

  int nchk = 0, nerr = 0;
  logic [31:0] tx_mem [0:127];
  int tx_wr = 0, tx_rd = 0;
  bit tx_fire = 0;
  logic [7:0]  all_b [0:255];
  int nall = 0;
  logic [31:0] rx_got [0:15];
  int nrx = 0, rxph = 0;
  int ncmd = 0, n_done = 0, n_enack = 0, n_earb = 0;
  bit eng_busy = 0;
  int err_at = -1, err_kind = 0;
  logic [7:0] rd_base = 8'hA0;
  logic [9:0]  cap_addr;
  logic        cap_ten, cap_read, cap_hs, cap_nack_ok;
  logic [1:0]  cap_end;
  logic [11:0] cap_len;

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // word feeder for the tx stream
  initial begin
    tx_valid = 1'b0; tx_data = '0;
    forever begin
      @(negedge clk);
      if (tx_fire) tx_rd++;
      tx_valid = (tx_rd < tx_wr);
      tx_data  = tx_valid ? tx_mem[tx_rd] : '0;
      #1 tx_fire = tx_valid && tx_ready;
    end
  end

  // receive word sink with periodic back-pressure
  initial begin
    rx_ready = 1'b0;
    forever begin
      @(negedge clk);
      rxph++;
      rx_ready = (rxph % 3) != 0;
      #1 if (rx_valid && rx_ready) begin rx_got[nrx] = rx_data; nrx++; end
    end
  end

  // pulse counters
  initial forever begin
    @(negedge clk);
    #1 if (rst_n) begin
      if (pkt_done) n_done++;
      if (err_nack) n_enack++;
      if (err_arb)  n_earb++;
    end
  end

  task automatic run_pkt();
    int total = int'(cap_len) + 1;
    int nb = 0;
    int ph = 0;
    bit stopped = 0;
    while (nb < total && !stopped) begin
      @(negedge clk);
      eng_nack = 1'b0; eng_arb = 1'b0; ph++;
      if (err_at >= 0 && nb == err_at) begin
        if (err_kind == 0) eng_nack = 1'b1; else eng_arb = 1'b1;
        err_at = -1;
        if (err_kind == 1 || !cap_nack_ok) begin
          stopped = 1; wb_ready = 1'b0; rb_valid = 1'b0;
        end
      end
      if (!stopped) begin
        if (cap_read) begin
          rb_valid = (ph % 4) != 3;
          rb_data  = rd_base + 8'(nb);
          #1 if (rb_valid && rb_ready) nb++;
        end else begin
          wb_ready = (ph % 3) != 2;
          #1 if (wb_valid && wb_ready) begin all_b[nall] = wb_data; nall++; nb++; end
        end
      end
    end
    @(negedge clk);
    eng_nack = 1'b0; eng_arb = 1'b0; wb_ready = 1'b0; rb_valid = 1'b0;
    repeat (3) @(negedge clk);
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  // bit engine model
  initial begin
    cmd_ready = 1'b0; wb_ready = 1'b0; rb_valid = 1'b0; rb_data = '0;
    eng_done = 1'b0; eng_nack = 1'b0; eng_arb = 1'b0;
    forever begin
      @(negedge clk);
      cmd_ready = 1'b1;
      #1 if (cmd_valid && rst_n) begin
        eng_busy = 1;
        cap_addr = cmd_addr; cap_ten = cmd_ten_bit; cap_read = cmd_read;
        cap_hs = cmd_hs; cap_nack_ok = cmd_nack_ok; cap_end = cmd_end; cap_len = cmd_len;
        ncmd++;
        @(negedge clk);
        cmd_ready = 1'b0;
        run_pkt();
        eng_busy = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog R12: actual hang expected completion");
    finish_run();
  end

  task automatic push(input logic [31:0] w);
    tx_mem[tx_wr] = w;
    tx_wr++;
  endtask

  task automatic hdr(input logic [11:0] len_m1, input logic [31:0] w2);
    push(32'h0001_0010);
    push({20'd0, len_m1});
    push(w2);
  endtask

  task automatic clear();
    ncmd = 0; nall = 0; nrx = 0; n_done = 0; n_enack = 0; n_earb = 0; err_at = -1;
  endtask

  task automatic wait_pkts(input int n);
    wait (ncmd >= n);
    wait (!eng_busy);
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk("R12 tx_ready", 32'(tx_ready), 1);
    chk("R12 cmd_valid", 32'(cmd_valid), 0);
    chk("R12 wb_valid", 32'(wb_valid), 0);
    chk("R12 rx_valid", 32'(rx_valid), 0);
    chk("R12 pulses", {29'd0, pkt_done, err_nack, err_arb}, 0);
  endtask

  task automatic t_write_basic();
    clear();
    hdr(12'd4, (32'h50 << 1) | (32'd1 << 17));
    push(32'h4433_2211); push(32'hDDCC_BB55);
    wait_pkts(1);
    chk("R1 len", 32'(cap_len), 4);
    chk("R2 addr7", 32'(cap_addr), 32'h50);
    chk("R2 ten", 32'(cap_ten), 0);
    chk("R3 stop", 32'(cap_end), 0);
    chk("R4 read", 32'(cap_read), 0);
    chk("R5 R7 count", nall, 5);
    chk("R5 R7 bytes", {all_b[0], all_b[1], all_b[2], all_b[3]}, 32'h1122_3344);
    chk("R5 last byte", 32'(all_b[4]), 32'h55);
    chk("R5 words used", tx_rd, tx_wr);
    chk("R8 done ie=1", n_done, 1);
  endtask

  task automatic t_write_flags();
    clear();
    hdr(12'd3, 32'h2A5 | (32'd1 << 18) | (32'd1 << 16) | (32'd1 << 22) | (32'd1 << 21));
    push(32'h0807_0605);
    wait_pkts(1);
    chk("R2 addr10", 32'(cap_addr), 32'h2A5);
    chk("R2 ten", 32'(cap_ten), 1);
    chk("R3 rstart", 32'(cap_end), 1);
    chk("R4 hs", 32'(cap_hs), 1);
    chk("R4 nack_ok", 32'(cap_nack_ok), 1);
    chk("R5 count", nall, 4);
    chk("R8 done ie=0", n_done, 0);
  endtask

  task automatic t_end_codes();
    clear();
    hdr(12'd0, (32'h11 << 1) | (32'd1 << 15));
    push(32'hFFFF_FF3C);
    wait_pkts(1);
    chk("R3 continue", 32'(cap_end), 2);
    chk("R5 one byte", 32'(all_b[0]), 32'h3C);
    clear();
    hdr(12'd0, (32'h11 << 1) | (32'd1 << 15) | (32'd1 << 16));
    push(32'h0000_0042);
    wait_pkts(1);
    chk("R3 priority", 32'(cap_end), 1);
    chk("R5 words used", tx_rd, tx_wr);
  endtask

  task automatic t_read();
    clear();
    hdr(12'd6, (32'h3A << 1) | (32'd1 << 19) | (32'd1 << 17));
    wait_pkts(1);
    chk("R4 read", 32'(cap_read), 1);
    chk("R6 R7 words", nrx, 2);
    chk("R6 word0", rx_got[0], 32'hA3A2_A1A0);
    chk("R6 zero fill", rx_got[1], 32'h00A6_A5A4);
    chk("R8 read done", n_done, 1);
  endtask

  task automatic t_nack_abort();
    clear();
    err_at = 2; err_kind = 0;
    hdr(12'd11, (32'h20 << 1) | (32'd1 << 17));
    push(32'h4433_2211); push(32'h8877_6655); push(32'hCCBB_AA99);
    hdr(12'd1, (32'h21 << 1) | (32'd1 << 17));
    push(32'h0000_BEEF);
    wait_pkts(2);
    chk("R9 err_nack", n_enack, 1);
    chk("R10 bytes", nall, 4);
    chk("R10 stream", {all_b[0], all_b[1], all_b[2], all_b[3]}, 32'h1122_EFBE);
    chk("R10 next len", 32'(cap_len), 1);
    chk("R10 next addr", 32'(cap_addr), 32'h21);
    chk("R10 words used", tx_rd, tx_wr);
    chk("R8 both done", n_done, 2);
  endtask

  task automatic t_nack_continue();
    clear();
    err_at = 1; err_kind = 0;
    hdr(12'd5, (32'h30 << 1) | (32'd1 << 21));
    push(32'hD4C3_B2A1); push(32'h0000_F6E5);
    wait_pkts(1);
    chk("R11 err_nack", n_enack, 1);
    chk("R11 count", nall, 6);
    chk("R11 tail", {all_b[4], all_b[5]}, 32'hE5F6);
  endtask

  task automatic t_arb_abort();
    clear();
    err_at = 3; err_kind = 1;
    hdr(12'd7, (32'h40 << 1) | (32'd1 << 21));
    push(32'h0403_0201); push(32'h0807_0605);
    hdr(12'd0, (32'h41 << 1));
    push(32'hAABB_CC77);
    wait_pkts(2);
    chk("R9 err_arb", n_earb, 1);
    chk("R10 arb bytes", nall, 4);
    chk("R10 arb stream", {all_b[0], all_b[1], all_b[2], all_b[3]}, 32'h0102_0377);
    chk("R10 arb next len", 32'(cap_len), 0);
    chk("R10 words used", tx_rd, tx_wr);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_basic();
    t_write_flags();
    t_end_codes();
    t_read();
    t_nack_abort();
    t_nack_continue();
    t_arb_abort();
    finish_run();
  end
endmodule